// File: doc/BRIEF.md
# Auxiliary Short-Circuit Fault Supervisor

This block supervises the auxiliary sense path of a switching LED controller. A digital comparator flag reports whether the auxiliary-winding sense voltage rose above a short-detect level (nominally 1 V). While the controller is switching, a fault timer accumulates operating time, and it is cleared only when that flag is seen high. If the timer reaches its limit (90 ms nominal) with no such pulse, an auxiliary short fault is declared and switching stops.

The response to the fault depends on a variant strap. With the strap high, the controller stays off until a full reset. With the strap low, it waits a fixed recovery period (4 s nominal), then enables switching again and starts a fresh timing window. While in either fault state the block asks for the compensation node to be grounded, so that the next start is clean. The request is withheld whenever undervoltage lockout is active. An undervoltage lockout on its own only pauses switching. It never grounds the compensation node and never clears the accumulated fault time, so repeated failed start attempts still add up to a fault.

Time is measured in ticks from an internal clock divider. Both limits are parameters in ticks, so simulation can use a short tick and silicon can use a real-time tick.

Top module: `aux_short_supervisor`

## Requirements
- R1: After reset the status code `fault_st_o` is 2'b00 (run), `sw_en_o` is 1 while `uvlo_i` is low, and `comp_gnd_o` is 0.
- R2: Any clock edge with `aux_above_i` high, in the run state, clears the fault timer. With the flag low and no lockout, the fault is taken on exactly the SHORT_TICKS*TICK_DIV-th following clock edge: `sw_en_o` stays 1 up to that edge and drops on it.
- R3: A flag pulse arriving one tick (TICK_DIV clocks) before the timeout prevents the fault, and a complete new window is then needed to trip.
- R4: While `uvlo_i` is high in the run state, `sw_en_o` and `comp_gnd_o` are 0 and the fault timer holds its value without clearing. Operating time before and after the lockout adds up toward the timeout.
- R5: If `latch_sel_i` is 1 at the trip edge, the status becomes 2'b10 (latched). `sw_en_o` is then 0 and `comp_gnd_o` is 1 until reset, whatever the other inputs do.
- R6: If `latch_sel_i` is 0 at the trip edge, the status becomes 2'b01 (recovery wait) for exactly RECOVER_TICKS*TICK_DIV clock edges, with `sw_en_o` 0 and `comp_gnd_o` 1. It then returns to 2'b00 with switching enabled and a fault timer restarted from zero.
- R7: `aux_above_i` has no effect while in either fault state: it neither shortens the recovery wait nor releases a latch.
- R8: During a fault state, `comp_gnd_o` is 0 in every cycle where `uvlo_i` is high, and the fault status is unchanged.
- R9: `latch_sel_i` is only sampled at the trip edge. Changing it during a recovery wait does not turn the wait into a latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_above_i | input | 1 | Comparator flag: auxiliary sense above short-detect level |
| uvlo_i | input | 1 | Undervoltage lockout active |
| latch_sel_i | input | 1 | Variant strap: 1 latch off on fault, 0 timed auto-recovery |
| sw_en_o | output | 1 | Switching enable to the gate-drive logic |
| comp_gnd_o | output | 1 | Request to ground the compensation node |
| fault_st_o | output | 2 | Status: 00 run, 01 recovery wait, 10 latched |

## Verification
The bench counts clock edges from the last qualifying pulse. It checks that the trip lands on exactly the edge named in R2, so a timer that is off by one tick or one clock is caught. A pulse placed one tick before expiry must hold off the fault. A timer that only restarts its divider, or ignores a late pulse, trips early there. A lockout placed in the middle of a window must neither restart nor advance the timer: a design that clears on lockout trips late, and one that counts through lockout trips early. The bench also checks that a latch survives sense pulses and strap changes, and that a recovery wait ends on the exact edge. A recovery wait that also honoured sense pulses, or re-read the strap, would show the wrong status at those points.

// File: rtl/asr_pkg.sv
package asr_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'b00,
      ST_WAIT  = 2'b01,
      ST_LATCH = 2'b10
   } sup_state_e;

endpackage

// File: rtl/asr_tick_gen.sv
module asr_tick_gen #(
   parameter int unsigned TICK_DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic clr_i,
   output logic tick_o
);

   localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   if (TICK_DIV < 1) begin : g_bad_div
      $error("asr_tick_gen: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_direct
      // every enabled clock is a tick
      assign tick_o = en_i && !clr_i;
   end else begin : g_divided
      logic [PW-1:0] presc_q;
      logic          wrap;

      assign wrap   = (presc_q == PW'(TICK_DIV - 1));
      assign tick_o = en_i && !clr_i && wrap;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            presc_q <= '0;
         end else if (clr_i) begin
            presc_q <= '0;
         end else if (en_i) begin
            presc_q <= wrap ? '0 : presc_q + 1'b1;
         end
      end

      // R2: prescaler never leaves its range
      p_presc_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
         presc_q <= PW'(TICK_DIV - 1));

      // R4: a paused prescaler keeps its phase
      p_presc_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         (!en_i && !clr_i) |=> $stable(presc_q));
   end

endmodule

// File: rtl/asr_short_timer.sv
module asr_short_timer #(
   parameter int unsigned SHORT_TICKS = 90
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   input  logic clr_i,
   output logic expire_o
);

   localparam int unsigned TW = $clog2(SHORT_TICKS + 1);

   if (SHORT_TICKS < 2) begin : g_bad_limit
      $error("asr_short_timer: SHORT_TICKS must be at least 2");
   end

   logic [TW-1:0] ticks_q;

   assign expire_o = inc_i && !clr_i && (ticks_q == TW'(SHORT_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks_q <= '0;
      end else if (clr_i) begin
         ticks_q <= '0;
      end else if (inc_i) begin
         ticks_q <= ticks_q + 1'b1;
      end
   end

   // R2: count never runs past the limit
   p_no_overflow_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      ticks_q <= TW'(SHORT_TICKS));

   // R4: no tick and no clear means the accumulated time is kept
   p_timer_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !clr_i) |=> $stable(ticks_q));

   // R2: a clear always lands at zero
   p_clear_zero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (ticks_q == '0));

endmodule

// File: rtl/asr_fault_fsm.sv
module asr_fault_fsm
   import asr_pkg::*;
#(
   parameter int unsigned RECOVER_TICKS = 4000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire_i,
   input  logic       tick_i,
   input  logic       latch_sel_i,
   output sup_state_e state_o
);

   localparam int unsigned RW = $clog2(RECOVER_TICKS);

   if (RECOVER_TICKS < 2) begin : g_bad_recover
      $error("asr_fault_fsm: RECOVER_TICKS must be at least 2");
   end

   sup_state_e    state_q;
   logic [RW-1:0] rec_q;
   logic          rec_done;

   assign rec_done = tick_i && (rec_q == RW'(RECOVER_TICKS - 1));
   assign state_o  = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         rec_q   <= '0;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               rec_q <= '0;
               if (expire_i) begin
                  state_q <= latch_sel_i ? ST_LATCH : ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (rec_done) begin
                  state_q <= ST_RUN;
                  rec_q   <= '0;
               end else if (tick_i) begin
                  rec_q <= rec_q + 1'b1;
               end
            end
            ST_LATCH: begin
               state_q <= ST_LATCH;
            end
            default: begin
               state_q <= ST_RUN;
               rec_q   <= '0;
            end
         endcase
      end
   end

   // R5: a latch is held until reset
   p_latch_sticky_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LATCH) |=> (state_q == ST_LATCH));

   // R2: leaving run needs a timer expiry
   p_trip_needs_expire_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !expire_i) |=> (state_q == ST_RUN));

   // R9: strap decides the fault kind only at the trip edge
   p_trip_kind_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && expire_i) |=>
         (state_q == ($past(latch_sel_i) ? ST_LATCH : ST_WAIT)));

   // R6: the recovery wait ends only on its last tick
   p_wait_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !rec_done) |=> (state_q == ST_WAIT));

   // R6: counter stays below its limit
   p_rec_range_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      rec_q <= RW'(RECOVER_TICKS - 1));

endmodule

// File: rtl/aux_short_supervisor.sv
module aux_short_supervisor
   import asr_pkg::*;
#(
   parameter int unsigned TICK_DIV      = 1000,
   parameter int unsigned SHORT_TICKS   = 90,
   parameter int unsigned RECOVER_TICKS = 4000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       aux_above_i,
   input  logic       uvlo_i,
   input  logic       latch_sel_i,
   output logic       sw_en_o,
   output logic       comp_gnd_o,
   output logic [1:0] fault_st_o
);

   sup_state_e state;
   logic       in_run;
   logic       in_fault;
   logic       operating;
   logic       tick_en;
   logic       tick_clr;
   logic       tick;
   logic       tmr_clr;
   logic       expire;

   assign in_run    = (state == ST_RUN);
   assign in_fault  = !in_run;
   assign operating = in_run && !uvlo_i;

   // the divider runs while switching or while a recovery wait is timed
   assign tick_en  = operating || (state == ST_WAIT);
   assign tick_clr = in_run && aux_above_i;
   assign tmr_clr  = in_fault || aux_above_i;

   asr_tick_gen #(
      .TICK_DIV (TICK_DIV)
   ) tick_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (tick_en),
      .clr_i  (tick_clr),
      .tick_o (tick)
   );

   asr_short_timer #(
      .SHORT_TICKS (SHORT_TICKS)
   ) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (tick && operating),
      .clr_i    (tmr_clr),
      .expire_o (expire)
   );

   asr_fault_fsm #(
      .RECOVER_TICKS (RECOVER_TICKS)
   ) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .expire_i    (expire),
      .tick_i      (tick),
      .latch_sel_i (latch_sel_i),
      .state_o     (state)
   );

   assign sw_en_o    = operating;
   assign comp_gnd_o = in_fault && !uvlo_i;
   assign fault_st_o = state;

   // R7: in a fault state the sense flag cannot move the status
   p_sense_ignored_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (fault_st_o == 2'b10) |=> (fault_st_o == 2'b10));

   // R8: lockout suppresses the ground request
   p_gnd_lockout_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      uvlo_i |-> !comp_gnd_o);

   // R4: switching and ground request never together
   p_exclusive_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_en_o && comp_gnd_o));

endmodule

// File: tb/aux_short_supervisor_tb_top.sv
module aux_short_supervisor_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int D  = 4;
   localparam int L  = 10;
   localparam int RC = 12;
   localparam int WIN = L * D;
   localparam int REC = RC * D;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       aux_above = 1'b0;
   logic       uvlo = 1'b0;
   logic       latch_sel = 1'b0;
   logic       sw_en;
   logic       comp_gnd;
   logic [1:0] fault_st;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   aux_short_supervisor #(
      .TICK_DIV      (D),
      .SHORT_TICKS   (L),
      .RECOVER_TICKS (RC)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .aux_above_i (aux_above),
      .uvlo_i      (uvlo),
      .latch_sel_i (latch_sel),
      .sw_en_o     (sw_en),
      .comp_gnd_o  (comp_gnd),
      .fault_st_o  (fault_st)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_out(input string req, input int st, input int en, input int gnd);
      chk(req, "fault_st", int'(fault_st), st);
      chk(req, "sw_en", int'(sw_en), en);
      chk(req, "comp_gnd", int'(comp_gnd), gnd);
   endtask

   task automatic do_reset();
      aux_above = 1'b0;
      uvlo      = 1'b0;
      latch_sel = 1'b0;
      rst_n     = 1'b0;
      step(2);
      rst_n     = 1'b1;
   endtask

   // one clock edge sees the flag high
   task automatic pulse();
      aux_above = 1'b1;
      step(1);
      aux_above = 1'b0;
   endtask

   task automatic t_reset_r1();
      do_reset();
      expect_out("R1", 0, 1, 0);
   endtask

   task automatic t_exact_trip_r2_r6();
      do_reset();
      pulse();
      step(WIN - 1);
      expect_out("R2", 0, 1, 0);
      step(1);
      expect_out("R2", 1, 0, 1);
      // recovery lasts REC edges; sense pulses are ignored (R7)
      pulse();
      step(REC / 2 - 1);
      expect_out("R7", 1, 0, 1);
      step(REC / 2 - 1);
      expect_out("R6", 1, 0, 1);
      step(1);
      expect_out("R6", 0, 1, 0);
      // fresh window from zero after recovery
      step(WIN - 1);
      expect_out("R6", 0, 1, 0);
      step(1);
      expect_out("R6", 1, 0, 1);
   endtask

   task automatic t_near_miss_r3();
      do_reset();
      pulse();
      step(WIN - D - 1);
      pulse();
      step(D);
      expect_out("R3", 0, 1, 0);
      step(WIN - D - 1);
      expect_out("R3", 0, 1, 0);
      step(1);
      expect_out("R3", 1, 0, 1);
   endtask

   task automatic t_uvlo_pause_r4();
      do_reset();
      pulse();
      step(13);
      uvlo = 1'b1;
      step(30);
      expect_out("R4", 0, 0, 0);
      uvlo = 1'b0;
      step(WIN - 13 - 1);
      expect_out("R4", 0, 1, 0);
      step(1);
      expect_out("R4", 1, 0, 1);
   endtask

   task automatic t_latch_r5_r7();
      do_reset();
      latch_sel = 1'b1;
      pulse();
      step(WIN);
      expect_out("R5", 2, 0, 1);
      pulse();
      latch_sel = 1'b0;
      step(REC + WIN);
      expect_out("R5", 2, 0, 1);
      pulse();
      expect_out("R7", 2, 0, 1);
   endtask

   task automatic t_gnd_uvlo_r8();
      do_reset();
      pulse();
      step(WIN);
      uvlo = 1'b1;
      step(1);
      expect_out("R8", 1, 0, 0);
      uvlo = 1'b0;
      step(1);
      expect_out("R8", 1, 0, 1);
   endtask

   task automatic t_strap_sample_r9();
      do_reset();
      pulse();
      step(WIN);
      expect_out("R9", 1, 0, 1);
      latch_sel = 1'b1;
      step(REC);
      expect_out("R9", 0, 1, 0);
      latch_sel = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : main
      t_reset_r1();
      t_exact_trip_r2_r6();
      t_near_miss_r3();
      t_uvlo_pause_r4();
      t_latch_r5_r7();
      t_gnd_uvlo_r8();
      t_strap_sample_r9();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule